// File: doc/BRIEF.md
# Flash Page Program-Verify Sequencer

This block runs the program/verify loop for one 128-byte page of a flash array. Software first writes the page's target bytes through a byte-write port while the block is idle, then strobes `start`. The block works out which bits must be driven from 1 to 0 and repeats a fixed cycle until every such bit reads back as 0, or until a parameterised loop limit is reached. Each cycle streams a pulse mask into the array's data latch, fires a timed write pulse, and then reads the whole page back to verify it.

The sequencer keeps three per-byte bit masks in inferred RAM. The reprogram mask holds bits still to be pulsed. The follow-up mask holds bits due a short extra pulse. The seen mask holds bits that have passed at least once. The write pulse is short for the early loops and long after that. A bit that first passes during an early loop gets one short follow-up pulse, issued after that loop's verify and before the next write pulse. A bit that has passed but later reads 1 again goes back into the reprogram mask. All pulse lengths come from microsecond parameters scaled by a clock-cycles-per-microsecond parameter.

Top module: `flash_pgm_seq`

## Requirements
- R1: `wr_en` writes `wr_data` into target byte `wr_addr` while `busy` is low. A write while `busy` is high is ignored and does not change the operation under way.
- R2: After reset, `busy`, `done`, `fail`, `fa_pgm_en` and `fa_pulse` are 0. A `start` while idle raises `busy` and `fa_pgm_en` on the next edge and clears `done` and `fail`. A `start` while `busy` is high is ignored. `done` or `fail` holds until the next accepted `start`.
- R3: A page whose target bytes are all 0xFF completes with `done`=1 and `fail`=0, and no write pulse is issued.
- R4: Before every pulse, the block writes all page bytes into the array latch (`fa_load`=1, `fa_addr`, `fa_wdata`), where a latch bit of 1 means "pulse this bit". A bit whose target value is 1 is never set in any latched mask. A write pulse covers exactly the bits whose target is 0 that have not yet read back 0.
- R5: `fa_pulse` stays high for SHORT_US×CYC_PER_US cycles in loops 1 to SHORT_LOOPS (30 µs, 6 loops by default), LONG_US×CYC_PER_US cycles in later loops (200 µs), and ADD_US×CYC_PER_US cycles for a follow-up pulse (10 µs).
- R6: After each write pulse, every page byte is read back (`fa_rd`=1, data on `fa_rdata` one edge later). A bit with target 0 that reads 0 is treated as programmed and leaves the reprogram mask.
- R7: A bit that reads 0 for the first time in loop 1 to SHORT_LOOPS gets one follow-up pulse. All such bits from one loop share a single follow-up pulse, issued after that loop's verify and before the next write pulse.
- R8: A bit that reads 0 for the first time in a loop after SHORT_LOOPS gets no follow-up pulse.
- R9: A programmed bit that later reads 1 returns to the reprogram mask and is pulsed in the next loop. When it passes again it gets no further follow-up pulse. A regression and a first pass in the same byte during one verify are both handled.
- R10: The loop count never exceeds MAX_LOOPS. If bits still read 1 after loop MAX_LOOPS, the operation ends with `fail`=1 and `done`=0.
- R11: The operation ends with `done`=1 once the reprogram mask is empty and no follow-up pulse is pending. No pulse follows.
- R12: `fa_pulse` is high only while `fa_pgm_en` is high. `fa_load`, `fa_rd` and `fa_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Target byte write strobe |
| wr_addr | input | 7 | Target byte index |
| wr_data | input | 8 | Target byte value |
| start | input | 1 | Start strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Page programmed |
| fail | output | 1 | Loop limit reached with bits left |
| fa_pgm_en | output | 1 | Array program mode enable |
| fa_pulse | output | 1 | Timed write pulse |
| fa_load | output | 1 | Latch write strobe |
| fa_rd | output | 1 | Verify read strobe |
| fa_addr | output | 7 | Latch or verify byte index |
| fa_wdata | output | 8 | Pulse mask byte for the latch |
| fa_rdata | input | 8 | Verify read data, valid one edge after `fa_rd` |

## Verification
The case that needs the most care is a verify pass in which two bits of one byte take opposite paths. One bit that had already passed now reads 1 and must go back into the reprogram mask. In the same read-modify-write, a neighbouring bit reads 0 for the first time and must be queued for a follow-up pulse. The bench provokes this with its cell model: right after the first follow-up pulse it resets the charge of one already-programmed bit, while a slower bit in the same byte is due to pass at the next verify. The scoreboard judges the result by the number of latched bits and the width of each later pulse. The follow-up pulse must carry only the neighbour, the next write pulse must carry only the regressed bit, and no further follow-up pulse may appear.

// File: rtl/flpv_pkg.sv
package flpv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_LOAD,
    ST_PULSE,
    ST_VERIFY,
    ST_ALOAD,
    ST_APULSE
  } seq_state_t;

  typedef enum logic [1:0] {
    RULE_INIT,
    RULE_VERIFY,
    RULE_CLEAR_ADD
  } rule_mode_t;

  // mask RAM slots
  localparam int MSK_RPG  = 0;
  localparam int MSK_SEEN = 1;
  localparam int MSK_ADD  = 2;
  localparam int MSK_NUM  = 3;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/flpv_ram.sv
module flpv_ram #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/flpv_pulse_timer.sv
module flpv_pulse_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [TW-1:0] width,
  output logic          pulse,
  output logic          fin
);

  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse  <= 1'b0;
      fin    <= 1'b0;
      remain <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        pulse  <= 1'b1;
        remain <= width - 1'b1;
      end else if (pulse) begin
        if (remain == '0) begin
          pulse <= 1'b0;
          fin   <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end

  // R5
  fin_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fin |-> ($past(pulse) && !pulse));

endmodule

// File: rtl/flpv_bit_rules.sv
module flpv_bit_rules
  import flpv_pkg::*;
#(
  parameter int BW = 8
) (
  input  rule_mode_t    mode,
  input  logic          early,
  input  logic [BW-1:0] tgt,
  input  logic [BW-1:0] rpg,
  input  logic [BW-1:0] seen,
  input  logic [BW-1:0] add,
  input  logic [BW-1:0] rd,
  output logic [BW-1:0] rpg_n,
  output logic [BW-1:0] seen_n,
  output logic [BW-1:0] add_n
);

  for (genvar b = 0; b < BW; b++) begin : g_bit
    logic need, pass, fresh;
    assign need  = ~tgt[b];
    assign pass  = need & ~rd[b];
    assign fresh = rpg[b] & pass & ~seen[b];

    always_comb begin
      unique case (mode)
        RULE_INIT: begin
          rpg_n[b]  = need;
          seen_n[b] = 1'b0;
          add_n[b]  = 1'b0;
        end
        RULE_VERIFY: begin
          rpg_n[b]  = need & rd[b];
          seen_n[b] = seen[b] | pass;
          add_n[b]  = add[b] | (fresh & early);
        end
        default: begin
          rpg_n[b]  = rpg[b];
          seen_n[b] = seen[b];
          add_n[b]  = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
  import flpv_pkg::*;
#(
  parameter int PAGE_BYTES  = 128,
  parameter int CYC_PER_US  = 50,
  parameter int SHORT_US    = 30,
  parameter int LONG_US     = 200,
  parameter int ADD_US      = 10,
  parameter int SHORT_LOOPS = 6,
  parameter int MAX_LOOPS   = 20,
  localparam int AW = $clog2(PAGE_BYTES),
  localparam int LW = $clog2(MAX_LOOPS + 1),
  localparam int TW = $clog2(max3(SHORT_US, LONG_US, ADD_US) * CYC_PER_US + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          fa_pgm_en,
  output logic          fa_pulse,
  output logic          fa_load,
  output logic          fa_rd,
  output logic [AW-1:0] fa_addr,
  output logic [7:0]    fa_wdata,
  input  logic [7:0]    fa_rdata
);

  localparam logic [AW-1:0] LAST      = AW'(PAGE_BYTES - 1);
  localparam logic [TW-1:0] SHORT_CYC = TW'(SHORT_US * CYC_PER_US);
  localparam logic [TW-1:0] LONG_CYC  = TW'(LONG_US * CYC_PER_US);
  localparam logic [TW-1:0] ADD_CYC   = TW'(ADD_US * CYC_PER_US);
  localparam logic [LW-1:0] LMAX      = LW'(MAX_LOOPS);
  localparam logic [LW-1:0] LSHORT    = LW'(SHORT_LOOPS);

  seq_state_t    st;
  logic [LW-1:0] loop_q;
  logic          iss;
  logic [AW-1:0] cnt;
  logic          v1, v2;
  logic [AW-1:0] a1, a2;
  logic          any_rpg, any_add;
  logic          pulse_go;
  logic [TW-1:0] pulse_w;
  logic          tmr_fin;

  logic [7:0] tgt_rd, tgt2;
  logic [7:0] m_rd [MSK_NUM];
  logic [7:0] m2   [MSK_NUM];
  logic [7:0] m_nx [MSK_NUM];

  // ---------------- storage ----------------
  flpv_ram #(.DEPTH(PAGE_BYTES), .WIDTH(8)) u_tgt (
    .clk(clk), .we(wr_en && !busy), .waddr(wr_addr), .wdata(wr_data),
    .raddr(cnt), .rdata(tgt_rd)
  );

  logic rule_act;
  assign rule_act = (st == ST_INIT) || (st == ST_VERIFY) || (st == ST_ALOAD);

  for (genvar i = 0; i < MSK_NUM; i++) begin : g_mask
    flpv_ram #(.DEPTH(PAGE_BYTES), .WIDTH(8)) u_msk (
      .clk(clk), .we(v2 && rule_act), .waddr(a2), .wdata(m_nx[i]),
      .raddr(cnt), .rdata(m_rd[i])
    );
  end

  // ---------------- read pipeline ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= iss;
      v2 <= v1;
    end
    a1   <= cnt;
    a2   <= a1;
    tgt2 <= tgt_rd;
    for (int i = 0; i < MSK_NUM; i++) m2[i] <= m_rd[i];
  end

  // ---------------- per-bit rules ----------------
  rule_mode_t rmode;
  always_comb begin
    unique case (st)
      ST_INIT:   rmode = RULE_INIT;
      ST_VERIFY: rmode = RULE_VERIFY;
      default:   rmode = RULE_CLEAR_ADD;
    endcase
  end

  flpv_bit_rules #(.BW(8)) u_rules (
    .mode(rmode), .early(loop_q <= LSHORT), .tgt(tgt2),
    .rpg(m2[MSK_RPG]), .seen(m2[MSK_SEEN]), .add(m2[MSK_ADD]), .rd(fa_rdata),
    .rpg_n(m_nx[MSK_RPG]), .seen_n(m_nx[MSK_SEEN]), .add_n(m_nx[MSK_ADD])
  );

  logic stream_end, any_rpg_c, any_add_c;
  assign stream_end = v2 && (a2 == LAST);
  assign any_rpg_c  = any_rpg | (|m_nx[MSK_RPG]);
  assign any_add_c  = any_add | (|m_nx[MSK_ADD]);

  // ---------------- pulse timer ----------------
  flpv_pulse_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .go(pulse_go), .width(pulse_w),
    .pulse(fa_pulse), .fin(tmr_fin)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      loop_q    <= '0;
      iss       <= 1'b0;
      cnt       <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fa_pgm_en <= 1'b0;
      any_rpg   <= 1'b0;
      any_add   <= 1'b0;
      pulse_go  <= 1'b0;
      pulse_w   <= '0;
    end else begin
      pulse_go <= 1'b0;
      if (iss) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) iss <= 1'b0;
      end
      if (v2 && (st == ST_INIT || st == ST_VERIFY)) begin
        any_rpg <= any_rpg_c;
        any_add <= any_add_c;
      end

      unique case (st)
        ST_IDLE: if (start) begin
          st        <= ST_INIT;
          busy      <= 1'b1;
          fa_pgm_en <= 1'b1;
          done      <= 1'b0;
          fail      <= 1'b0;
          loop_q    <= LW'(1);
          iss       <= 1'b1;
          cnt       <= '0;
          any_rpg   <= 1'b0;
          any_add   <= 1'b0;
        end
        ST_INIT: if (stream_end) begin
          if (any_rpg_c) begin
            st  <= ST_LOAD;
            iss <= 1'b1;
            cnt <= '0;
          end else begin
            st        <= ST_IDLE;
            busy      <= 1'b0;
            fa_pgm_en <= 1'b0;
            done      <= 1'b1;
          end
        end
        ST_LOAD: if (stream_end) begin
          st       <= ST_PULSE;
          pulse_go <= 1'b1;
          pulse_w  <= (loop_q <= LSHORT) ? SHORT_CYC : LONG_CYC;
        end
        ST_PULSE: if (tmr_fin) begin
          st      <= ST_VERIFY;
          iss     <= 1'b1;
          cnt     <= '0;
          any_rpg <= 1'b0;
          any_add <= 1'b0;
        end
        ST_VERIFY: if (stream_end) begin
          if (any_add_c) begin
            st  <= ST_ALOAD;
            iss <= 1'b1;
            cnt <= '0;
          end else if (!any_rpg_c) begin
            st        <= ST_IDLE;
            busy      <= 1'b0;
            fa_pgm_en <= 1'b0;
            done      <= 1'b1;
          end else if (loop_q == LMAX) begin
            st        <= ST_IDLE;
            busy      <= 1'b0;
            fa_pgm_en <= 1'b0;
            fail      <= 1'b1;
          end else begin
            st     <= ST_LOAD;
            loop_q <= loop_q + 1'b1;
            iss    <= 1'b1;
            cnt    <= '0;
          end
        end
        ST_ALOAD: if (stream_end) begin
          st       <= ST_APULSE;
          pulse_go <= 1'b1;
          pulse_w  <= ADD_CYC;
        end
        ST_APULSE: if (tmr_fin) begin
          any_add <= 1'b0;
          if (!any_rpg) begin
            st        <= ST_IDLE;
            busy      <= 1'b0;
            fa_pgm_en <= 1'b0;
            done      <= 1'b1;
          end else if (loop_q == LMAX) begin
            st        <= ST_IDLE;
            busy      <= 1'b0;
            fa_pgm_en <= 1'b0;
            fail      <= 1'b1;
          end else begin
            st     <= ST_LOAD;
            loop_q <= loop_q + 1'b1;
            iss    <= 1'b1;
            cnt    <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // ---------------- array interface ----------------
  logic load_ph;
  assign load_ph = (st == ST_LOAD) || (st == ST_ALOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      fa_rd    <= 1'b0;
      fa_load  <= 1'b0;
      fa_addr  <= '0;
      fa_wdata <= '0;
    end else begin
      fa_rd   <= iss && (st == ST_VERIFY);
      fa_load <= v1 && load_ph;
      if (iss && st == ST_VERIFY) fa_addr <= cnt;
      else if (v1 && load_ph)     fa_addr <= a1;
      fa_wdata <= (st == ST_ALOAD) ? m_rd[MSK_ADD] : m_rd[MSK_RPG];
    end
  end

  // ---------------- assertions ----------------
  // R12
  pulse_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    fa_pulse |-> fa_pgm_en);

  // R12
  port_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({fa_pulse, fa_load, fa_rd}) <= 1);

  // R10
  loop_bound_chk: assert property (@(posedge clk) disable iff (rst)
    loop_q <= LMAX);

  // R2
  end_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> (!busy && !(done && fail)));

  // R11
  done_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (!fa_pulse && !any_add));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done && !fail));

endmodule

// File: tb/flash_pgm_seq_tb_top.sv
module flash_pgm_seq_tb_top;

  localparam int PB = 128;
  localparam int NB = PB * 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, start;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic       busy, done, fail, fa_pgm_en, fa_pulse, fa_load, fa_rd;
  logic [6:0] fa_addr;
  logic [7:0] fa_wdata;
  logic [7:0] fa_rdata = 8'hFF;

  always #5 clk = ~clk;

  flash_pgm_seq #(.PAGE_BYTES(PB), .CYC_PER_US(1), .MAX_LOOPS(10)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .busy(busy), .done(done), .fail(fail),
    .fa_pgm_en(fa_pgm_en), .fa_pulse(fa_pulse), .fa_load(fa_load), .fa_rd(fa_rd),
    .fa_addr(fa_addr), .fa_wdata(fa_wdata), .fa_rdata(fa_rdata)
  );

  // ---------------- cell model ----------------
  logic [7:0] tgt   [PB];
  logic [7:0] latch [PB];
  int         pc    [NB];
  int         need  [NB];

  function automatic logic [7:0] cell_byte(int a);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[k] = (pc[a*8+k] >= need[a*8+k]) ? 1'b0 : 1'b1;
    return b;
  endfunction

  always @(posedge clk) begin
    if (fa_load) latch[fa_addr] <= fa_wdata;
    if (fa_rd)   fa_rdata <= cell_byte(int'(fa_addr));
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    int    w;
    int    p;
    string req;
  } exp_t;
  exp_t exp_q[$];

  int nchk = 0, nfail = 0;
  int mchk = 0, mfail = 0;
  int npulses = 0, clr_seq = 0, clr_seen = 0;
  int knock_at = 0, knock_bit = 0;
  int proto_err = 0, bad_latch = 0;
  int wcnt = 0, pop = 0;
  logic pul_prev = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic mcheck(input bit ok, input string req, input int act, input int exp);
    mchk++;
    if (!ok) begin
      mfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (clr_seq != clr_seen) begin
      for (int i = 0; i < NB; i++) pc[i] = 0;
      npulses  = 0;
      clr_seen = clr_seq;
    end
    if (!rst) begin
      if (fa_load && fa_rd) proto_err++;
      if (fa_pulse && (fa_load || fa_rd || !fa_pgm_en)) proto_err++;
      if (fa_pulse && !pul_prev) begin
        pop  = 0;
        wcnt = 0;
        for (int i = 0; i < PB; i++) begin
          pop += $countones(latch[i]);
          if ((latch[i] & tgt[i]) != 8'h00) bad_latch++;
          for (int k = 0; k < 8; k++) if (latch[i][k]) pc[i*8+k]++;
        end
      end
      if (fa_pulse) wcnt++;
      if (!fa_pulse && pul_prev) begin
        npulses++;
        if (exp_q.size() == 0) begin
          mcheck(1'b0, "R11 unexpected pulse", wcnt, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          mcheck(wcnt == e.w, "R5 pulse width", wcnt, e.w);
          mcheck(pop == e.p, e.req, pop, e.p);
        end
        if (knock_at == npulses) pc[knock_bit] = 0;
      end
      pul_prev = fa_pulse;
    end
  end

  // ---------------- driver tasks ----------------
  task automatic push(input int w, input int p, input string req);
    exp_t e;
    e.w = w; e.p = p; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic erase();
    for (int i = 0; i < PB; i++) tgt[i] = 8'hFF;
    for (int i = 0; i < NB; i++) need[i] = 1000;
    knock_at = 0;
    clr_seq++;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic zero_bit(input int byte_i, input int bit_i, input int n);
    tgt[byte_i][bit_i] = 1'b0;
    need[byte_i*8+bit_i] = n;
  endtask

  task automatic load_target();
    for (int i = 0; i < PB; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 7'(i); wr_data = tgt[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_op();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0 && fail == 1'b0, "R2 busy after start", int'(busy), 1);
  endtask

  task automatic wait_end(input bit exp_done, input bit exp_fail, input string tag);
    while (!(done || fail)) @(negedge clk);
    repeat (3) @(negedge clk);
    check(done == exp_done, {tag, " done"}, int'(done), int'(exp_done));
    check(fail == exp_fail, {tag, " fail"}, int'(fail), int'(exp_fail));
    check(exp_q.size() == 0, {tag, " pulses left over"}, exp_q.size(), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired act=1 exp=0");
    $display("End of test - %0d assertions evaluated, %0d failures",
             nchk + mchk + 1, nfail + mfail + 1);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    rst = 1'b1; wr_en = 1'b0; start = 1'b0; wr_addr = '0; wr_data = '0;
    for (int i = 0; i < PB; i++) latch[i] = 8'h00;
    erase();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    check({busy, done, fail, fa_pgm_en, fa_pulse} == 5'b0, "R2 reset state",
          int'({busy, done, fail, fa_pgm_en, fa_pulse}), 0);

    // R3 all-ones page: no pulses
    erase();
    load_target();
    start_op();
    wait_end(1'b1, 1'b0, "R3");
    check(npulses == 0, "R3 pulse count", npulses, 0);

    // early, mid and late finishers; R7 and R8; writes and start while busy ignored (R1)
    erase();
    zero_bit(0, 0, 1);
    zero_bit(64, 7, 3);
    zero_bit(127, 3, 8);
    load_target();
    push(30, 3, "R4 loop1 mask");
    push(10, 1, "R7 follow-up loop1");
    push(30, 2, "R6 loop2 mask");
    push(30, 2, "R4 loop3 mask");
    push(10, 1, "R7 follow-up loop3");
    push(30, 1, "R4 loop4 mask");
    push(30, 1, "R4 loop5 mask");
    push(30, 1, "R4 loop6 mask");
    push(200, 1, "R5 loop7 mask");
    push(200, 1, "R8 loop8 mask");
    start_op();
    while (npulses < 3) @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'd127; wr_data = 8'hFF; start = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; start = 1'b0;
    wait_end(1'b1, 1'b0, "R6/R11 and R1");
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R2 done held", int'(done), 1);

    // R10 loop limit reached
    erase();
    zero_bit(3, 2, 1);
    zero_bit(10, 5, 50);
    load_target();
    push(30, 2, "R4 loop1 mask");
    push(10, 1, "R7 follow-up loop1");
    for (int i = 0; i < 5; i++) push(30, 1, "R4 short loop mask");
    for (int i = 0; i < 4; i++) push(200, 1, "R10 long loop mask");
    start_op();
    wait_end(1'b0, 1'b1, "R10");

    // R9 regression and first pass in the same byte, same verify
    erase();
    zero_bit(5, 0, 1);
    zero_bit(5, 1, 2);
    load_target();
    knock_at  = 2;
    knock_bit = 5 * 8 + 0;
    push(30, 2, "R4 loop1 mask");
    push(10, 1, "R7 follow-up loop1");
    push(30, 1, "R9 loop2 mask");
    push(10, 1, "R9 follow-up carries only new bit");
    push(30, 1, "R9 regressed bit repulsed");
    start_op();
    wait_end(1'b1, 1'b0, "R9");

    check(proto_err == 0, "R12 port exclusivity", proto_err, 0);
    check(bad_latch == 0, "R4 target-1 bit latched", bad_latch, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk + mchk, nfail + mfail);
    $finish;
  end

endmodule